// File: doc/BRIEF.md
# Mixed-Attribute Control and Status Register Bank

This block holds a small set of software-visible control and status fields behind a plain word-addressed register port. Each field has one access attribute: plain read-write, read-only status, cleared by a read, cleared by a read but still writable, cleared by writing ones, writable only while a global unlock bit is set, or loaded from strap pins. Hardware event inputs set the status fields. Strap inputs give the initial value of the hardware-initialised field.

Three reset classes apply. `rst_ni` is the heaviest, the switch-level fundamental reset, and returns every field to its initial value. `fund_rst_i` is a synchronous fundamental reset. It clears everything except the lock-gated fields and reloads the strap field. `hot_rst_i` is a synchronous light reset and clears only the non-sticky fields.

Word map (word address on `addr_i`). Reserved bits read as zero.
- Word 0: bit 0 `unlock` (read-write, reset 0); bits 15:8 `gen_cfg` (read-write, reset 0xA5); bits 23:16 `stk_cfg` (read-write, sticky, reset 0x3C).
- Word 1: bits 15:0 `lock_cfg` (write-when-unlocked, switch-sticky, reset 0x1234); bits 31:24 `strap_val` (hardware-initialised from `strap_i`).
- Word 2: bits 7:0 `evt_flags` (write-one-to-clear, sticky, set by `evt_i`); bits 15:8 `live_stat` (read-only, follows `stat_i`); bits 23:16 `rd_flags` (read-to-clear, set by `rc_set_i`).
- Word 3: bits 15:0 `mbox` (read-to-clear with write).

Top module: `csr_attr_bank`

## Requirements
- R1: After `rst_ni` is released, word 0 reads 0x003CA500, `lock_cfg` reads 0x1234, `strap_val` holds `strap_i`, and `evt_flags`, `rd_flags` and `mbox` read zero.
- R2: A write changes only the bytes whose `be_i` bit is set (bit n covers data bits 8n+7:8n). Reserved bit positions read as zero and ignore writes.
- R3: A read of word 2 returns the current `rd_flags`, and the field reads zero afterwards. Writes to `rd_flags` have no effect.
- R4: Byte-enabled writes update `mbox`. A read of word 3 returns its value and then clears it.
- R5: A 1 on an `evt_i` bit sets the matching `evt_flags` bit. Writing 1 clears that bit, writing 0 leaves it unchanged, and no hardware input clears it.
- R6: When an `evt_i` bit and a write of 1 to the same `evt_flags` bit occur in the same cycle, the bit ends up set.
- R7: When a read of word 2 and an `rc_set_i` bit occur in the same cycle, the read returns the value before that cycle, and the bit is set afterwards.
- R8: Writes to `lock_cfg` take effect only while `unlock` is 1. Otherwise they are dropped.
- R9: `strap_val` ignores writes. It is reloaded from `strap_i` only by `rst_ni` or `fund_rst_i`, and keeps its value through `hot_rst_i`.
- R10: `live_stat` follows `stat_i`, and writes have no effect on it.
- R11: `hot_rst_i` returns `unlock`, `gen_cfg`, `rd_flags` and `mbox` to their defaults. It leaves `stk_cfg`, `evt_flags`, `lock_cfg` and `strap_val` unchanged.
- R12: `fund_rst_i` returns every field except `lock_cfg` to its default and reloads `strap_val`. `lock_cfg` keeps its value.
- R13: `rdata_o` is loaded on the clock edge at which `rd_i` is high and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low switch-level fundamental reset |
| fund_rst_i | input | 1 | Synchronous fundamental reset strobe |
| hot_rst_i | input | 1 | Synchronous light (hot) reset strobe |
| addr_i | input | ADDR_W | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte enables for writes |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| evt_i | input | EVT_W | Set pulses for `evt_flags` |
| rc_set_i | input | RC_W | Set pulses for `rd_flags` |
| stat_i | input | STAT_W | Live status shown in `live_stat` |
| strap_i | input | STRAP_W | Strap value for `strap_val` |

## Verification
The bench sweeps all sixteen byte-enable patterns over word 0, so a lane swap or a write into reserved bits shows up as a wrong readback. It walks every `evt_flags` bit and also drives same-cycle collisions. A design that gave the clear priority over the set would lose the event. A design that cleared the field after reading it, rather than in the read cycle, would drop a flag that arrives together with the read. The bench then applies each reset class after it has changed the strap pins and filled the fields. A sticky field cleared by the hot reset, a lock-gated field lost on the fundamental reset, or a strap reloaded at the wrong time each gives a wrong word.

// File: rtl/csr_attr_pkg.sv
package csr_attr_pkg;
  typedef enum logic [2:0] {
    A_RO, A_RW, A_RC, A_RCW, A_W1C, A_RWL, A_HWI
  } attr_e;

  typedef enum logic [1:0] {
    CLS_PLAIN,   // cleared by any reset
    CLS_STICKY,  // survives hot reset
    CLS_SWSTK    // survives everything but rst_ni
  } rst_cls_e;

  function automatic logic [31:0] fmask(int w, int lsb);
    logic [63:0] t;
    t = (64'd1 << w) - 64'd1;
    return t[31:0] << lsb;
  endfunction
endpackage

// File: rtl/csr_access.sv
module csr_access #(
  parameter int ADDR_W = 2,
  localparam int NW = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [3:0]        be_i,
  output logic [NW-1:0]     wsel_o,
  output logic [NW-1:0]     rsel_o,
  output logic [31:0]       bmask_o
);
  for (genvar w = 0; w < NW; w++) begin : g_sel
    assign wsel_o[w] = wr_i && (addr_i == ADDR_W'(w));
    assign rsel_o[w] = rd_i && (addr_i == ADDR_W'(w));
  end
  for (genvar b = 0; b < 4; b++) begin : g_lane
    assign bmask_o[8*b +: 8] = {8{be_i[b]}};
  end
endmodule

// File: rtl/csr_field.sv
module csr_field
  import csr_attr_pkg::*;
#(
  parameter attr_e    ATTR = A_RW,
  parameter rst_cls_e CLS  = CLS_PLAIN,
  parameter int       W    = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fund_rst_i,
  input  logic         hot_rst_i,
  input  logic         load_i,
  input  logic         unlock_i,
  input  logic         wr_i,
  input  logic         rd_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] wmask_i,
  input  logic [W-1:0] hw_i,
  output logic [W-1:0] q_o
);
  logic         clr, wr_en, w1c, rd_clr, ld;
  logic [W-1:0] q_q, q_d, setv;

  always_comb begin
    unique case (CLS)
      CLS_PLAIN:  clr = fund_rst_i | hot_rst_i;
      CLS_STICKY: clr = fund_rst_i;
      default:    clr = 1'b0;
    endcase
    wr_en  = wr_i && (ATTR == A_RW || ATTR == A_RCW || (ATTR == A_RWL && unlock_i));
    w1c    = wr_i && (ATTR == A_W1C);
    rd_clr = rd_i && (ATTR == A_RC || ATTR == A_RCW);
    ld     = load_i && (ATTR == A_HWI);
    setv   = (ATTR == A_RC || ATTR == A_RCW || ATTR == A_W1C) ? hw_i : '0;
    q_d = q_q;
    if (wr_en)       q_d = (q_q & ~wmask_i) | (wdata_i & wmask_i);
    else if (rd_clr) q_d = '0;
    if (w1c)         q_d = q_d & ~(wdata_i & wmask_i);
    q_d = q_d | setv;  // hardware set wins over any clear
    if (ld)          q_d = hw_i;
    if (clr)         q_d = RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST;
    else         q_q <= q_d;
  end

  assign q_o = (ATTR == A_RO) ? hw_i : q_q;

  if (ATTR == A_W1C) begin : g_chk_w1c
    a_r5_no_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_i && !clr) |=> ((($past(q_q)) & ~q_q) == '0));
    a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr) |=> ((q_q & $past(hw_i)) == $past(hw_i)));
  end
  if (ATTR == A_RC) begin : g_chk_rc
    a_r3_wr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !rd_i && !clr && hw_i == '0) |=> $stable(q_q));
    a_r7_rd_keeps_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !clr) |=> (q_q == $past(hw_i)));
  end
  if (ATTR == A_RCW) begin : g_chk_rcw
    a_r4_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && !clr && hw_i == '0) |=> (q_q == '0));
  end
  if (ATTR == A_RWL) begin : g_chk_rwl
    a_r8_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !unlock_i && !clr) |=> $stable(q_q));
  end
  if (ATTR == A_HWI) begin : g_chk_hwi
    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!load_i && !clr) |=> $stable(q_q));
  end
endmodule

// File: rtl/csr_attr_bank.sv
module csr_attr_bank
  import csr_attr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int CFG_W   = 8,   // fields are limited to one byte lane (lock to two)
  parameter int STK_W   = 8,
  parameter int LOCK_W  = 16,
  parameter int STRAP_W = 8,
  parameter int EVT_W   = 8,
  parameter int STAT_W  = 8,
  parameter int RC_W    = 8,
  parameter int MBOX_W  = 16,
  parameter logic [CFG_W-1:0]  CFG_RST  = 8'hA5,
  parameter logic [STK_W-1:0]  STK_RST  = 8'h3C,
  parameter logic [LOCK_W-1:0] LOCK_RST = 16'h1234
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fund_rst_i,
  input  logic               hot_rst_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [31:0]        wdata_i,
  input  logic [3:0]         be_i,
  input  logic               rd_i,
  output logic [31:0]        rdata_o,
  input  logic [EVT_W-1:0]   evt_i,
  input  logic [RC_W-1:0]    rc_set_i,
  input  logic [STAT_W-1:0]  stat_i,
  input  logic [STRAP_W-1:0] strap_i
);
  localparam int NW       = 1 << ADDR_W;
  localparam int CFG_LSB  = 8;
  localparam int STK_LSB  = 16;
  localparam int LOCK_LSB = 0;
  localparam int STRP_LSB = 24;
  localparam int EVT_LSB  = 0;
  localparam int STAT_LSB = 8;
  localparam int RC_LSB   = 16;
  localparam int MBOX_LSB = 0;
  localparam logic [31:0] VM0 = fmask(1, 0) | fmask(CFG_W, CFG_LSB) | fmask(STK_W, STK_LSB);
  localparam logic [31:0] VM1 = fmask(LOCK_W, LOCK_LSB) | fmask(STRAP_W, STRP_LSB);
  localparam logic [31:0] VM2 = fmask(EVT_W, EVT_LSB) | fmask(STAT_W, STAT_LSB) | fmask(RC_W, RC_LSB);
  localparam logic [31:0] VM3 = fmask(MBOX_W, MBOX_LSB);

  logic [NW-1:0] wsel, rsel;
  logic [31:0]   bm;
  logic          init_q;
  logic          unlock_q;
  logic [CFG_W-1:0]   cfg_q;
  logic [STK_W-1:0]   stk_q;
  logic [LOCK_W-1:0]  lock_q;
  logic [STRAP_W-1:0] strap_q;
  logic [EVT_W-1:0]   evt_q;
  logic [STAT_W-1:0]  stat_q;
  logic [RC_W-1:0]    rc_q;
  logic [MBOX_W-1:0]  mbox_q;
  logic [31:0]        word [NW];
  logic [31:0]        rdata_q;

  csr_access #(.ADDR_W(ADDR_W)) u_access (
    .addr_i, .wr_i, .rd_i, .be_i, .wsel_o(wsel), .rsel_o(rsel), .bmask_o(bm)
  );

  // strap capture one cycle after a reset that reloads it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= fund_rst_i;
  end

  csr_field #(.ATTR(A_RW), .CLS(CLS_PLAIN), .W(1), .RST(1'b0)) u_unlock (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[0]), .rd_i(rsel[0]), .wdata_i(wdata_i[0]), .wmask_i(bm[0]),
    .hw_i(1'b0), .q_o(unlock_q));
  csr_field #(.ATTR(A_RW), .CLS(CLS_PLAIN), .W(CFG_W), .RST(CFG_RST)) u_cfg (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[0]), .rd_i(rsel[0]), .wdata_i(wdata_i[CFG_LSB +: CFG_W]),
    .wmask_i(bm[CFG_LSB +: CFG_W]), .hw_i('0), .q_o(cfg_q));
  csr_field #(.ATTR(A_RW), .CLS(CLS_STICKY), .W(STK_W), .RST(STK_RST)) u_stk (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[0]), .rd_i(rsel[0]), .wdata_i(wdata_i[STK_LSB +: STK_W]),
    .wmask_i(bm[STK_LSB +: STK_W]), .hw_i('0), .q_o(stk_q));
  csr_field #(.ATTR(A_RWL), .CLS(CLS_SWSTK), .W(LOCK_W), .RST(LOCK_RST)) u_lock (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(unlock_q),
    .wr_i(wsel[1]), .rd_i(rsel[1]), .wdata_i(wdata_i[LOCK_LSB +: LOCK_W]),
    .wmask_i(bm[LOCK_LSB +: LOCK_W]), .hw_i('0), .q_o(lock_q));
  csr_field #(.ATTR(A_HWI), .CLS(CLS_STICKY), .W(STRAP_W), .RST('0)) u_strap (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(init_q), .unlock_i(1'b0),
    .wr_i(wsel[1]), .rd_i(rsel[1]), .wdata_i(wdata_i[STRP_LSB +: STRAP_W]),
    .wmask_i(bm[STRP_LSB +: STRAP_W]), .hw_i(strap_i), .q_o(strap_q));
  csr_field #(.ATTR(A_W1C), .CLS(CLS_STICKY), .W(EVT_W), .RST('0)) u_evt (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[2]), .rd_i(rsel[2]), .wdata_i(wdata_i[EVT_LSB +: EVT_W]),
    .wmask_i(bm[EVT_LSB +: EVT_W]), .hw_i(evt_i), .q_o(evt_q));
  csr_field #(.ATTR(A_RO), .CLS(CLS_PLAIN), .W(STAT_W), .RST('0)) u_stat (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[2]), .rd_i(rsel[2]), .wdata_i(wdata_i[STAT_LSB +: STAT_W]),
    .wmask_i(bm[STAT_LSB +: STAT_W]), .hw_i(stat_i), .q_o(stat_q));
  csr_field #(.ATTR(A_RC), .CLS(CLS_PLAIN), .W(RC_W), .RST('0)) u_rc (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[2]), .rd_i(rsel[2]), .wdata_i(wdata_i[RC_LSB +: RC_W]),
    .wmask_i(bm[RC_LSB +: RC_W]), .hw_i(rc_set_i), .q_o(rc_q));
  csr_field #(.ATTR(A_RCW), .CLS(CLS_PLAIN), .W(MBOX_W), .RST('0)) u_mbox (
    .clk_i, .rst_ni, .fund_rst_i, .hot_rst_i, .load_i(1'b0), .unlock_i(1'b0),
    .wr_i(wsel[3]), .rd_i(rsel[3]), .wdata_i(wdata_i[MBOX_LSB +: MBOX_W]),
    .wmask_i(bm[MBOX_LSB +: MBOX_W]), .hw_i('0), .q_o(mbox_q));

  always_comb begin
    for (int i = 0; i < NW; i++) word[i] = '0;
    word[0][0]                      = unlock_q;
    word[0][CFG_LSB +: CFG_W]       = cfg_q;
    word[0][STK_LSB +: STK_W]       = stk_q;
    word[1][LOCK_LSB +: LOCK_W]     = lock_q;
    word[1][STRP_LSB +: STRAP_W]    = strap_q;
    word[2][EVT_LSB +: EVT_W]       = evt_q;
    word[2][STAT_LSB +: STAT_W]     = stat_q;
    word[2][RC_LSB +: RC_W]         = rc_q;
    word[3][MBOX_LSB +: MBOX_W]     = mbox_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= word[addr_i];
  end
  assign rdata_o = rdata_q;

  function automatic logic [31:0] vmask(logic [ADDR_W-1:0] a);
    case (int'(a))
      0:       return VM0;
      1:       return VM1;
      2:       return VM2;
      3:       return VM3;
      default: return '0;
    endcase
  endfunction

  a_r2_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i) |-> ((rdata_o & ~vmask($past(addr_i))) == '0));
  a_r13_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/csr_attr_bank_bench.sv
module csr_attr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fund_rst = 1'b0, hot_rst = 1'b0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic [7:0]  evt = '0, rc_set = '0, stat = 8'h81, strap = 8'h5C;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // bench-side model
  logic [31:0] m_w0;
  logic [15:0] m_lock, m_mbox;
  logic [7:0]  m_strap, m_evt, m_rc;
  localparam logic [31:0] VM0 = 32'h00FF_FF01;

  always #2.5 clk = ~clk;

  csr_attr_bank u_csr_attr_bank (
    .clk_i(clk), .rst_ni(rst_n), .fund_rst_i(fund_rst), .hot_rst_i(hot_rst),
    .addr_i(addr), .wr_i(wr), .wdata_i(wdata), .be_i(be), .rd_i(rd),
    .rdata_o(rdata), .evt_i(evt), .rc_set_i(rc_set), .stat_i(stat), .strap_i(strap)
  );

  function automatic logic [31:0] expand(logic [3:0] b);
    return {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
  endfunction

  function automatic logic [31:0] exp_word(int a);
    case (a)
      0: return m_w0;
      1: return {m_strap, 8'h00, m_lock};
      2: return {8'h00, m_rc, stat, m_evt};
      default: return {16'h0000, m_mbox};
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%08h exp=%08h", req, act, exp);
    end
  endtask

  task automatic do_wr(int a, logic [31:0] d, logic [3:0] b);
    @(negedge clk);
    addr = 2'(a); wdata = d; be = b; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
  endtask

  task automatic do_rd(int a, output logic [31:0] d);
    @(negedge clk);
    addr = 2'(a); rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(int a, string req);
    logic [31:0] d;
    do_rd(a, d);
    chk(req, d, exp_word(a));
    if (a == 2) m_rc = '0;
    if (a == 3) m_mbox = '0;
  endtask

  task automatic pulse_evt(logic [7:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  task automatic pulse_rc(logic [7:0] v);
    @(negedge clk); rc_set = v;
    @(negedge clk); rc_set = '0;
  endtask

  task automatic all_words(string req);
    for (int a = 0; a < 4; a++) rd_chk(a, req);
  endtask

  task automatic model_reset();
    m_w0 = 32'h003C_A500; m_lock = 16'h1234; m_strap = strap;
    m_evt = '0; m_rc = '0; m_mbox = '0;
  endtask

  initial begin
    logic [31:0] d, v, held;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R9 R10: reset state, strap and live status
    all_words("R1");

    // R2: sweep all byte-enable patterns over word 0
    for (int b = 0; b < 16; b++) begin
      v = 32'h9E37_79B9 * (b + 1);
      do_wr(0, v, 4'(b));
      m_w0 = (m_w0 & ~(expand(4'(b)) & VM0)) | (v & expand(4'(b)) & VM0);
      rd_chk(0, "R2");
    end
    do_wr(0, 32'h0, 4'h1); m_w0[0] = 1'b0;

    // R8: write-when-unlocked
    do_wr(1, 32'hFFFF_ABCD, 4'hF);
    rd_chk(1, "R8");
    do_wr(0, 32'h1, 4'h1); m_w0[0] = 1'b1;
    do_wr(1, 32'h0000_BEEF, 4'h1); m_lock = {m_lock[15:8], 8'hEF};
    rd_chk(1, "R8");
    do_wr(1, 32'hFFFF_6789, 4'hF); m_lock = 16'h6789;
    rd_chk(1, "R9");  // strap byte must ignore the write
    do_wr(0, 32'h0, 4'h1); m_w0[0] = 1'b0;
    do_wr(1, 32'h0000_1111, 4'h3);
    rd_chk(1, "R8");

    // R5: walk each event bit
    for (int i = 0; i < 8; i++) begin
      pulse_evt(8'(1 << i)); m_evt = m_evt | 8'(1 << i);
      rd_chk(2, "R5");
      do_wr(2, 32'h0, 4'hF);
      rd_chk(2, "R5");
      do_wr(2, 32'(1 << i), 4'h1); m_evt = '0;
      rd_chk(2, "R5");
    end

    // R6: set and clear collide
    pulse_evt(8'hFF); m_evt = 8'hFF;
    @(negedge clk);
    addr = 2'd2; wdata = 32'hFF; be = 4'hF; wr = 1'b1; evt = 8'h10;
    @(negedge clk);
    wr = 1'b0; evt = '0; be = '0;
    m_evt = 8'h10;
    rd_chk(2, "R6");
    do_wr(2, 32'h10, 4'h1); m_evt = '0;

    // R3: read-to-clear, writes ignored
    pulse_rc(8'h5A); m_rc = 8'h5A;
    do_wr(2, 32'h00FF_0000, 4'hF);
    rd_chk(2, "R3");
    rd_chk(2, "R3");

    // R7: read and set in the same cycle
    pulse_rc(8'h01); m_rc = 8'h01;
    @(negedge clk);
    addr = 2'd2; rd = 1'b1; rc_set = 8'h02;
    @(negedge clk);
    rd = 1'b0; rc_set = '0;
    chk("R7", rdata, exp_word(2));
    m_rc = 8'h02;
    rd_chk(2, "R7");

    // R4: read-clear with write
    do_wr(3, 32'h1234_BEEF, 4'h3); m_mbox = 16'hBEEF;
    do_wr(3, 32'h0000_7700, 4'h2); m_mbox = 16'h77EF;
    rd_chk(3, "R4");
    rd_chk(3, "R4");

    // R10: live status follows input, writes ignored
    stat = 8'h3E;
    do_wr(2, 32'h0000_FF00, 4'h2);
    rd_chk(2, "R10");

    // R13: read data holds between reads
    do_rd(0, held);
    do_wr(0, 32'h0011_2200, 4'hF); m_w0 = 32'h0011_2200;
    @(negedge clk);
    chk("R13", rdata, held);
    rd_chk(0, "R13");

    // R11: hot reset
    do_wr(0, 32'h0077_8801, 4'hF); m_w0 = 32'h0077_8801;
    pulse_evt(8'h33); m_evt = 8'h33;
    pulse_rc(8'h44); m_rc = 8'h44;
    do_wr(3, 32'h0000_1111, 4'h3); m_mbox = 16'h1111;
    strap = 8'hA7;
    @(negedge clk); hot_rst = 1'b1;
    @(negedge clk); hot_rst = 1'b0;
    m_w0 = (m_w0 & 32'h00FF_0000) | 32'h0000_A500; m_rc = '0; m_mbox = '0;
    all_words("R11");

    // R12: fundamental reset
    do_wr(0, 32'h0066_5501, 4'hF); m_w0 = 32'h0066_5501;
    pulse_rc(8'h08); m_rc = 8'h08;
    do_wr(3, 32'h0000_2222, 4'h3); m_mbox = 16'h2222;
    @(negedge clk); fund_rst = 1'b1;
    @(negedge clk); fund_rst = 1'b0;
    @(negedge clk);
    m_w0 = 32'h003C_A500; m_evt = '0; m_rc = '0; m_mbox = '0; m_strap = 8'hA7;
    all_words("R12");

    // R1: full reset brings back the lock default
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    all_words("R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R13 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule